// File: doc/BRIEF.md
# Erase-block protection state controller

This block keeps the write-protection state of every erase block in a flash array. Each block has two stored bits: a lock bit and a lock-down bit. The block combines them with a write-protect input pin. Upstream command decoding supplies three single-cycle strobes (lock, unlock, lock-down) and a block index. The controller updates the addressed block on the next clock edge.

Each block's status is reported as a two-bit field, {locked-down, locked}. The program/erase logic also gets a per-block permit signal. While the write-protect pin is low, a locked-down block is forced to show as locked. The stored lock bit is kept, so the block returns to its earlier value when the pin goes high again. Lock-down can only be left through reset.

The write-protect pin is registered once inside the block. Both the reported status and the command rules use that registered level. The number of blocks is a parameter; the index is $clog2(NUM_BLOCKS) bits wide.

Top module: `blk_lock_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every block has lock bit 1 and lock-down bit 0. Every status field reads 2'b01 and every modify_ok_o bit is 0.
- R2: A valid lock strobe sets the addressed block's locked bit (status bit 2i) at the next clock edge. Its locked-down bit (status bit 2i+1) is unchanged, and every other block is unchanged.
- R3: A valid unlock strobe clears the addressed block's lock bit at the next edge. The exception is a block that is locked-down while the registered write-protect level is 0: its state does not change.
- R4: A valid lock-down strobe sets both the locked-down bit and the lock bit of the addressed block at the next edge, whatever the write-protect level.
- R5: One edge after wp_i goes low, every locked-down block reports locked = 1. Blocks that are not locked-down keep their locked bit.
- R6: One edge after wp_i goes high, a locked-down block reports the lock bit it held before. That bit includes any lock command received while the pin was low.
- R7: No command clears a block's locked-down bit. Only reset clears it.
- R8: modify_ok_o[i] is 1 exactly when block i's reported locked bit is 0.
- R9: A cycle with more than one strobe high, or with blk_addr_i >= NUM_BLOCKS, changes no block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wp_i | input | 1 | Write-protect pin level (low = protect locked-down blocks) |
| lock_i | input | 1 | Lock command strobe |
| unlock_i | input | 1 | Unlock command strobe |
| lockdown_i | input | 1 | Lock-down command strobe |
| blk_addr_i | input | $clog2(NUM_BLOCKS) | Target block index |
| status_o | output | 2*NUM_BLOCKS | Per block i: bit 2i+1 locked-down, bit 2i locked |
| modify_ok_o | output | NUM_BLOCKS | Per block program/erase permitted |

## Verification
Directed steps walk one block through every triple of (write-protect, locked-down, locked) and cover each transition the command and pin rules allow. These steps separate a real state change from an ignored unlock, and a restored lock bit after the pin rises from one that was lost.

Seeded random cycles then mix single strobes, several strobes at once, out-of-range indices and pin toggles across all blocks. This shows that only the addressed block moves and that illegal cycles are ignored. A reset in the middle of the run checks that lock-down is cleared only by reset.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  typedef struct packed {
    logic dn;  // locked-down
    logic lk;  // stored lock bit
  } prot_t;

  localparam prot_t PROT_RESET = '{dn: 1'b0, lk: 1'b1};

  // locked bit as seen by software and program/erase logic
  function automatic logic shown_lock(prot_t s, logic wp);
    return s.lk | (s.dn & ~wp);
  endfunction
endpackage

// File: rtl/blk_lock_decode.sv
module blk_lock_decode #(
  parameter int NUM_BLOCKS = 6,
  localparam int AW = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lock_i,
  input  logic                  unlock_i,
  input  logic                  lockdown_i,
  input  logic [AW-1:0]         blk_addr_i,
  output logic [NUM_BLOCKS-1:0] lock_hit_o,
  output logic [NUM_BLOCKS-1:0] unlock_hit_o,
  output logic [NUM_BLOCKS-1:0] ldn_hit_o
);
  logic single_cmd, in_range, cmd_ok;

  assign single_cmd = (32'(lock_i) + 32'(unlock_i) + 32'(lockdown_i)) == 32'd1;
  assign in_range   = {1'b0, blk_addr_i} < (AW+1)'(NUM_BLOCKS);
  assign cmd_ok     = single_cmd & in_range;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_sel
    logic sel;
    assign sel             = cmd_ok & (blk_addr_i == AW'(i));
    assign lock_hit_o[i]   = sel & lock_i;
    assign unlock_hit_o[i] = sel & unlock_i;
    assign ldn_hit_o[i]    = sel & lockdown_i;
  end

  // R9: at most one block sees at most one command per cycle
  p_single_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({lock_hit_o, unlock_hit_o, ldn_hit_o}) <= 1);
  // R9: multiple strobes never reach a block
  p_multi_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && unlock_i) |-> (lock_hit_o == '0 && unlock_hit_o == '0));
endmodule

// File: rtl/blk_lock_cell.sv
module blk_lock_cell
  import blk_lock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wp_q_i,
  input  logic lock_hit_i,
  input  logic unlock_hit_i,
  input  logic ldn_hit_i,
  output logic dn_o,
  output logic lk_o,
  output logic modify_ok_o
);
  prot_t st_q, st_d;
  logic  unlock_blocked;

  assign unlock_blocked = st_q.dn & ~wp_q_i;

  always_comb begin
    st_d = st_q;
    if (ldn_hit_i) begin
      st_d.dn = 1'b1;
      st_d.lk = 1'b1;
    end else if (lock_hit_i) begin
      st_d.lk = 1'b1;
    end else if (unlock_hit_i && !unlock_blocked) begin
      st_d.lk = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PROT_RESET;
    else         st_q <= st_d;
  end

  assign dn_o        = st_q.dn;
  assign lk_o        = shown_lock(st_q, wp_q_i);
  assign modify_ok_o = ~lk_o;

  p_lock_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_hit_i |=> (st_q.lk && $stable(st_q.dn)));
  p_unlock_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_hit_i && st_q.dn && !wp_q_i) |=> $stable(st_q));
  p_ldn_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldn_hit_i |=> (st_q.dn && st_q.lk));
  p_dn_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.dn |=> st_q.dn);
  p_idle_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lock_hit_i || unlock_hit_i || ldn_hit_i) |=> $stable(st_q));
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl #(
  parameter int NUM_BLOCKS = 6,
  localparam int AW = $clog2(NUM_BLOCKS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wp_i,
  input  logic                    lock_i,
  input  logic                    unlock_i,
  input  logic                    lockdown_i,
  input  logic [AW-1:0]           blk_addr_i,
  output logic [2*NUM_BLOCKS-1:0] status_o,
  output logic [NUM_BLOCKS-1:0]   modify_ok_o
);
  logic                  wp_q;
  logic [NUM_BLOCKS-1:0] lock_hit, unlock_hit, ldn_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wp_q <= 1'b0;
    else         wp_q <= wp_i;
  end

  blk_lock_decode #(.NUM_BLOCKS(NUM_BLOCKS)) u_decode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lock_i       (lock_i),
    .unlock_i     (unlock_i),
    .lockdown_i   (lockdown_i),
    .blk_addr_i   (blk_addr_i),
    .lock_hit_o   (lock_hit),
    .unlock_hit_o (unlock_hit),
    .ldn_hit_o    (ldn_hit)
  );

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    blk_lock_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wp_q_i       (wp_q),
      .lock_hit_i   (lock_hit[i]),
      .unlock_hit_i (unlock_hit[i]),
      .ldn_hit_i    (ldn_hit[i]),
      .dn_o         (status_o[2*i+1]),
      .lk_o         (status_o[2*i]),
      .modify_ok_o  (modify_ok_o[i])
    );

    // R5: with pin low, a locked-down block never permits modification
    p_wp_low_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wp_i && status_o[2*i+1]) |=> !modify_ok_o[i]);
  end
endmodule

// File: tb/blk_lock_ctrl_tb_top.sv
module blk_lock_ctrl_tb_top;
  localparam int N  = 6;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wp = 1'b0, lk_s = 1'b0, ul_s = 1'b0, ld_s = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2*N-1:0] status;
  logic [N-1:0]   mod_ok;

  int checks = 0, failures = 0;
  bit done = 0;

  logic m_lk [N];
  logic m_dn [N];
  logic m_wp;

  always #10 clk = ~clk;

  blk_lock_ctrl #(.NUM_BLOCKS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wp_i(wp), .lock_i(lk_s), .unlock_i(ul_s),
    .lockdown_i(ld_s), .blk_addr_i(addr), .status_o(status), .modify_ok_o(mod_ok)
  );

  function automatic logic [2*N-1:0] exp_status();
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) begin
      v[2*i+1] = m_dn[i];
      v[2*i]   = m_lk[i] | (m_dn[i] & ~m_wp);
    end
    return v;
  endfunction

  function automatic logic [N-1:0] exp_mod(logic [2*N-1:0] s);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ~s[2*i];
    return v;
  endfunction

  task automatic check(string tag);
    logic [2*N-1:0] es;
    es = exp_status();
    checks++;
    if (status !== es) begin
      failures++;
      $display("FAIL %s status actual=%h expected=%h", tag, status, es);
    end
    checks++;
    if (mod_ok !== exp_mod(es)) begin
      failures++;
      $display("FAIL %s R8 modify_ok actual=%b expected=%b", tag, mod_ok, exp_mod(es));
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_lk[i] = 1'b1; m_dn[i] = 1'b0; end
    m_wp = 1'b0;
  endtask

  // inputs set at negedge, model advanced at posedge, compared at next negedge
  task automatic step(logic w, logic l, logic u, logic d, int a);
    int b;
    wp = w; lk_s = l; ul_s = u; ld_s = d; addr = AW'(a);
    @(posedge clk);
    b = int'(addr);
    if ((int'(l) + int'(u) + int'(d)) == 1 && b < N) begin
      if (d) begin m_dn[b] = 1'b1; m_lk[b] = 1'b1; end
      else if (l) m_lk[b] = 1'b1;
      else if (!(m_dn[b] && !m_wp)) m_lk[b] = 1'b0;
    end
    m_wp = w;
    @(negedge clk);
    lk_s = 1'b0; ul_s = 1'b0; ld_s = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk);
    checks++;
    if (status !== {N{2'b01}}) begin
      failures++;
      $display("FAIL R1 status in reset actual=%h expected=%h", status, {N{2'b01}});
    end
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    int seed_v;
    model_reset();
    repeat (2) @(negedge clk);
    do_reset();
    check("R1");
    step(1, 0, 0, 0, 0); check("R1 idle");

    step(1, 0, 1, 0, 2); check("R3 unlock blk2");
    step(1, 1, 0, 0, 2); check("R2 lock blk2");
    step(1, 0, 1, 0, 2); check("R3 unlock blk2 again");
    step(1, 0, 0, 1, 3); check("R4 lockdown blk3 wp high");
    step(1, 0, 1, 0, 3); check("R3 unlock lockdown blk3 wp high");
    step(0, 0, 0, 0, 0); check("R5 wp low forces blk3");
    step(0, 0, 1, 0, 3); check("R3 unlock ignored blk3 wp low");
    step(1, 0, 0, 0, 0); check("R6 wp high restores blk3 unlocked");
    step(0, 0, 0, 0, 0); check("R5 wp low again");
    step(0, 1, 0, 0, 3); check("R2 lock blk3 while wp low");
    step(1, 0, 0, 0, 0); check("R6 wp high restores blk3 locked");
    step(0, 0, 0, 1, 4); check("R4 lockdown blk4 wp low");
    step(0, 1, 1, 0, 2); check("R9 two strobes");
    step(0, 0, 1, 1, 3); check("R9 unlock plus lockdown");
    step(1, 0, 1, 0, 6); check("R9 addr 6 out of range");
    step(1, 0, 1, 0, 7); check("R9 addr 7 out of range");
    step(1, 0, 1, 0, 4); check("R7 lockdown kept after unlock");

    seed_v = $urandom(32'd2024);
    for (int k = 0; k < 600; k++) begin
      logic w, l, u, d;
      int r;
      r = int'($urandom_range(15, 0));
      w = ($urandom_range(7, 0) == 0) ? ~wp : wp;
      l = 0; u = 0; d = 0;
      if (r < 4) l = 1;
      else if (r < 9) u = 1;
      else if (r < 11) d = 1;
      else if (r == 11) begin l = 1; d = 1; end
      step(w, l, u, d, int'($urandom_range(7, 0)));
      check("R2 R3 R4 R5 R6 R7 R9 random");
      if (k == 300) begin
        do_reset();
        check("R7 reset clears lockdown");
      end
    end

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule